// File: doc/BRIEF.md
# Reset and Boot Vector Sequencer

This block sits next to an 8-bit microcontroller core. It turns an external active-high reset pin into a clean core reset, and it picks the address the core fetches first when that reset ends. The pin is synchronized and then qualified by a count of machine-cycle strobes. The count runs only while the oscillator reports stable. A request is honoured only after the pin has stayed high for a full qualification window, so a short disturbance on the pin cannot restart the core.

When the core reset is released, the block samples the program-store-enable pin level and a nonvolatile boot status bit in that same cycle. If either one asks for boot entry, the start address is a page built from an 8-bit boot vector. Otherwise the start address is zero. The address is then held until the next release. A power-on flag is set only by the chip-level power-up reset, so it survives warm resets from the pin. Software reads it at bit 0 of a small register port and clears it by writing 1 to that bit. The block drives nothing toward on-chip RAM, so a warm reset leaves memory contents as they were.

Top module: `rst_boot_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `core_rst_o` is 1, `start_addr_o` is 0000h and `reg_rdata_o` bit 0 (the power-on flag) is 1. The core reset stays asserted until a qualified pin reset has completed.
- R2: `rst_pin_i` passes through a two-flop synchronizer. `core_rst_o` rises only after the synchronized pin has been high while `osc_ok_i` was 1 for `MIN_MC` (default 2) cycles in which `mc_tick_i` was 1.
- R3: If the pin goes low before `MIN_MC` strobes have been counted, the pulse is ignored and the count restarts from zero. Two such short pulses in a row never assert `core_rst_o`.
- R4: While `osc_ok_i` is 0 the count is held at zero, so a pin held high asserts no reset.
- R5: Once a qualified reset has been seen, `core_rst_o` falls in the cycle after the synchronized pin goes low.
- R6: At release, if `pse_n_i` is 1 and `boot_stat_i` is 0, `start_addr_o` becomes 0000h.
- R7: At release, if `pse_n_i` is 0, `start_addr_o` becomes {`boot_vec_i`, 8'h00}.
- R8: At release, if `boot_stat_i` is 1, `start_addr_o` becomes {`boot_vec_i`, 8'h00}.
- R9: `start_addr_o` changes only in the release cycle. Changes to `pse_n_i`, `boot_stat_i` or `boot_vec_i` at any other time have no effect on it.
- R10: A write (`reg_wr_i`=1) with `reg_wdata_i` bit 0 = 1 clears the power-on flag. A write with bit 0 = 0 leaves the flag unchanged. Bits 7..1 of `reg_rdata_o` read 0.
- R11: A warm reset through `rst_pin_i` leaves the power-on flag unchanged.
- R12: The power-on flag is set only by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous active-low |
| rst_pin_i | input | 1 | External reset pin, active-high, asynchronous |
| osc_ok_i | input | 1 | Oscillator stable |
| mc_tick_i | input | 1 | One-cycle machine-cycle strobe |
| pse_n_i | input | 1 | Program-store-enable pin level (0 requests boot) |
| boot_stat_i | input | 1 | Nonvolatile boot status bit |
| boot_vec_i | input | 8 | Boot page high byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, bit 0 is the power-on flag |
| core_rst_o | output | 1 | Reset to the core, active-high |
| start_addr_o | output | 16 | First fetch address |

## Verification
The bench sends glitches shorter than the strobe window, including two back to back. A design that kept a partial count would then fire a core reset on the second glitch. It holds the pin high while the oscillator is not ready, which catches a counter that ignores that input. After release it moves the pin, status and vector inputs and checks that the start address stays put; a transparent address path would follow those inputs. It also clears the power-on flag and then applies a warm reset, which exposes a flag tied to the wrong reset.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned REG_W  = 8;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WARM  = 2'd2
  } rst_state_e;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rbs_mc_count.sv
module rbs_mc_count #(
  parameter int unsigned MIN_MC = 2,
  localparam int unsigned CW = $clog2(MIN_MC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic osc_ok_i,
  input  logic tick_i,
  output logic qual_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          full;

  assign full   = (cnt_q == CW'(MIN_MC));
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_s_i || !osc_ok_i) cnt_d = '0;
    else if (tick_i && !full)  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual_o = full && pin_s_i && osc_ok_i;
endmodule

// File: rtl/rbs_boot_sel.sv
module rbs_boot_sel
  import rbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              release_i,
  input  logic              pse_n_i,
  input  logic              boot_stat_i,
  input  logic [VEC_W-1:0]  boot_vec_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              boot_req;

  always_comb begin
    boot_req = !pse_n_i || boot_stat_i;
    addr_d   = boot_req ? {boot_vec_i, {(ADDR_W-VEC_W){1'b0}}} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (release_i) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rbs_pof_reg.sv
module rbs_pof_reg
  import rbs_pkg::*;
#(
  parameter int unsigned FLAG_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  assign flag_en = wr_i && wdata_i[FLAG_BIT];

  always_comb begin
    flag_d = flag_q;
    if (flag_en) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
  import rbs_pkg::*;
#(
  parameter int unsigned MIN_MC    = 2,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin_i,
  input  logic              osc_ok_i,
  input  logic              mc_tick_i,
  input  logic              pse_n_i,
  input  logic              boot_stat_i,
  input  logic [VEC_W-1:0]  boot_vec_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              core_rst_o,
  output logic [ADDR_W-1:0] start_addr_o
);
  logic       pin_s;
  logic       qual;
  logic       release_c;
  rst_state_e st_q;
  rst_state_e st_d;

  rbs_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rst_pin_i), .q_o(pin_s)
  );

  rbs_mc_count #(.MIN_MC(MIN_MC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .osc_ok_i(osc_ok_i),
    .tick_i(mc_tick_i), .qual_o(qual)
  );

  always_comb begin
    st_d      = st_q;
    release_c = 1'b0;
    case (st_q)
      ST_HOLD: if (qual) st_d = ST_WARM;
      ST_RUN:  if (qual) st_d = ST_WARM;
      ST_WARM: if (!pin_s) begin
                 st_d      = ST_RUN;
                 release_c = 1'b1;
               end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign core_rst_o = (st_q != ST_RUN);

  rbs_boot_sel u_sel (
    .clk(clk), .rst_n(rst_n), .release_i(release_c), .pse_n_i(pse_n_i),
    .boot_stat_i(boot_stat_i), .boot_vec_i(boot_vec_i), .addr_o(start_addr_o)
  );

  rbs_pof_reg #(.FLAG_BIT(0)) u_pof (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
  import rbs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              osc_ok_i,
  input logic              pse_n_i,
  input logic              boot_stat_i,
  input logic [VEC_W-1:0]  boot_vec_i,
  input logic              reg_wr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              core_rst_o,
  input logic [ADDR_W-1:0] start_addr_o
);
  p_osc_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |-> $past(osc_ok_i));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(core_rst_o) |-> $stable(start_addr_o));

  p_boot_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_rst_o) && (!$past(pse_n_i) || $past(boot_stat_i)))
      |-> start_addr_o == {$past(boot_vec_i), 8'h00});

  p_zero_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_rst_o) && $past(pse_n_i) && !$past(boot_stat_i))
      |-> start_addr_o == '0);

  p_pof_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_wdata_i[0]) |=> !reg_rdata_o[0]);

  p_pof_no_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(reg_rdata_o[0]));

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[REG_W-1:1] == '0);
endmodule

bind rst_boot_seq rbs_checker u_chk (.*);

// File: tb/tb_rst_boot_seq.sv
module tb_rst_boot_seq;
  logic        clk;
  logic        rst_n;
  logic        rst_pin_i;
  logic        osc_ok_i;
  logic        mc_tick_i;
  logic        pse_n_i;
  logic        boot_stat_i;
  logic [7:0]  boot_vec_i;
  logic        reg_wr_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  reg_rdata_o;
  logic        core_rst_o;
  logic [15:0] start_addr_o;

  int n_chk;
  int n_bad;
  bit done;

  rst_boot_seq dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {pse_n, stat, vec[7:0], expected addr[15:0]}
  localparam logic [25:0] VEC_TBL [6] = '{
    {1'b1, 1'b0, 8'hA5, 16'h0000},
    {1'b0, 1'b0, 8'h3C, 16'h3C00},
    {1'b1, 1'b1, 8'h7E, 16'h7E00},
    {1'b0, 1'b1, 8'hFF, 16'hFF00},
    {1'b1, 1'b0, 8'h12, 16'h0000},
    {1'b0, 1'b0, 8'h01, 16'h0100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pin_pulse(input int hi_clks);
    rst_pin_i = 1'b1;
    wait_clk(hi_clks);
    rst_pin_i = 1'b0;
    wait_clk(8);
  endtask

  // machine-cycle strobe: one clock in four
  initial begin
    mc_tick_i = 1'b0;
    forever begin
      @(negedge clk); mc_tick_i = 1'b1;
      @(negedge clk); mc_tick_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  end

  initial begin
    wait_clk(20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_pin_i = 1'b0; osc_ok_i = 1'b1; pse_n_i = 1'b1;
    boot_stat_i = 1'b0; boot_vec_i = 8'h00; reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
    wait_clk(3);
    check("R1 core_rst in reset", core_rst_o, 1);
    check("R1 addr in reset", start_addr_o, 0);
    check("R1 pof in reset", reg_rdata_o, 8'h01);
    rst_n = 1'b1;
    wait_clk(20);
    check("R1 core_rst held until pin reset", core_rst_o, 1);

    // cold start completion via pin
    pin_pulse(20);
    check("R5 cold release", core_rst_o, 0);
    check("R6 cold addr", start_addr_o, 0);

    // vector table of warm resets with boot selection
    for (int k = 0; k < 6; k++) begin
      pse_n_i = VEC_TBL[k][25]; boot_stat_i = VEC_TBL[k][24];
      boot_vec_i = VEC_TBL[k][23:16];
      rst_pin_i = 1'b1;
      wait_clk(20);
      check("R2 warm reset asserted", core_rst_o, 1);
      rst_pin_i = 1'b0;
      wait_clk(8);
      check("R5 warm release", core_rst_o, 0);
      check("R6 R7 R8 start addr", start_addr_o, VEC_TBL[k][15:0]);
    end

    // R2 exact assert timing: no reset after only one strobe counted
    rst_pin_i = 1'b1;
    wait_clk(3);
    check("R2 not yet asserted", core_rst_o, 0);
    wait_clk(15);
    check("R2 asserted after window", core_rst_o, 1);
    rst_pin_i = 1'b0;
    wait_clk(8);

    // R9 inputs changing while running
    boot_vec_i = 8'h55; pse_n_i = 1'b0; boot_stat_i = 1'b1;
    wait_clk(10);
    check("R9 addr held", start_addr_o, 16'h0100);
    pse_n_i = 1'b1; boot_stat_i = 1'b0;

    // R3 two short glitches back to back
    pin_pulse(3);
    check("R3 glitch one ignored", core_rst_o, 0);
    pin_pulse(3);
    check("R3 glitch two ignored", core_rst_o, 0);
    check("R3 addr unchanged", start_addr_o, 16'h0100);

    // R4 oscillator not stable
    osc_ok_i = 1'b0;
    rst_pin_i = 1'b1;
    wait_clk(40);
    check("R4 no reset without osc", core_rst_o, 0);
    rst_pin_i = 1'b0;
    osc_ok_i = 1'b1;
    wait_clk(8);

    // R10 register port
    reg_wr_i = 1'b1; reg_wdata_i = 8'hFE;
    wait_clk(1);
    reg_wr_i = 1'b0;
    wait_clk(1);
    check("R10 write 0 keeps flag", reg_rdata_o, 8'h01);
    reg_wr_i = 1'b1; reg_wdata_i = 8'h01;
    wait_clk(1);
    reg_wr_i = 1'b0;
    wait_clk(1);
    check("R10 write 1 clears flag", reg_rdata_o, 8'h00);

    // R11 warm reset keeps cleared flag
    pin_pulse(20);
    check("R11 flag after warm reset", reg_rdata_o, 8'h00);
    check("R6 addr after warm reset", start_addr_o, 0);

    // R12 power-up sets flag again
    rst_n = 1'b0;
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(2);
    check("R12 flag set by power-up", reg_rdata_o, 8'h01);
    check("R1 core_rst after power-up", core_rst_o, 1);
    check("R1 addr after power-up", start_addr_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule